// File: doc/BRIEF.md
# Excluded-Set Random Tag Generator

This block picks 4-bit memory tags for a tag-checked memory system. A tag is chosen by stepping from a start tag through the 16 tag values, wrapping modulo 16 and skipping every value marked in an exclusion mask. Each accepted request runs in one of two operations. In random mode the step count comes from a 16-bit LFSR seed, and the start tag comes from a state register. In add/subtract mode the start tag is the pointer's own tag field, and the step count is an immediate from the request.

Random mode writes the chosen tag and the advanced seed back into the state register, so the next random request continues the sequence. The sequence is fully deterministic. Add/subtract mode also adds a signed offset to the pointer. Both modes return the pointer with its tag field replaced.

The selection runs one step per clock. While a request is in flight the block refuses new ones, and it marks the result with a single-cycle valid pulse. A small register port sets the configuration exclusion mask and the state register, and reads them back.

Top module: `excl_tag_gen`

## Requirements
- R1: If the effective exclusion mask is 16'hFFFF, the result tag is 0 whatever the start tag and step count are.
- R2: With a step count of 0, the result is the start tag if it is not excluded. Otherwise the block advances (tag+1) mod 16 until it reaches a non-excluded value, so start 15 with 15 excluded and 0 allowed gives 0.
- R3: With a step count N > 0, the block makes N moves. Each move advances mod 16 past every excluded value and stops on the next allowed one.
- R4: In random mode the step count is built over four LFSR steps, i = 0..3. In each step, fb = s[5]^s[3]^s[2]^s[0], s becomes {fb, s[15:1]}, and fb becomes bit i of the step count.
- R5: State register layout: start tag in bits [3:0], seed in bits [23:8], all other bits read as 0. A random-mode request leaves the chosen tag and the four-step-advanced seed in it, in the same cycle the result is signalled. An add/subtract request leaves it unchanged.
- R6: Random mode uses req_mask_i OR the configuration mask as its exclusion mask. Add/subtract mode uses only the configuration mask and ignores req_mask_i.
- R7: The pointer tag field is bits [59:56]. In add/subtract mode (req_op_i = 1) the result pointer is req_ptr_i plus the sign-extended req_addr_ofs_i, with bits [59:56] replaced by the result tag. In random mode (req_op_i = 0) only bits [59:56] change.
- R8: A request is accepted when req_valid_i and req_ready_o are both high, and req_ready_o is low from the cycle after acceptance until the result. Each accepted request gives exactly one single-cycle rsp_valid_o pulse, in order.
- R9: cfg_sel_i = 0 selects the configuration mask (bits [15:0]) and cfg_sel_i = 1 selects the state register. cfg_we_i writes cfg_wdata_i at the clock edge, and cfg_rdata_o shows the selected register. Both registers reset to 0.
- R10: Unless the mask is all ones, the result tag is never an excluded value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request present |
| req_ready_o | output | 1 | Block idle and able to accept |
| req_op_i | input | 1 | 0 random, 1 add/subtract |
| req_ptr_i | input | PTR_W | Input pointer |
| req_mask_i | input | 16 | Operand exclusion mask (random mode only) |
| req_tag_ofs_i | input | 4 | Tag step count (add/subtract mode) |
| req_addr_ofs_i | input | OFS_W | Signed address offset (add/subtract mode) |
| cfg_we_i | input | 1 | Register write strobe |
| cfg_sel_i | input | 1 | Register select: 0 mask, 1 state |
| cfg_wdata_i | input | 32 | Register write data |
| cfg_rdata_o | output | 32 | Selected register contents |
| rsp_valid_o | output | 1 | Single-cycle result pulse |
| rsp_ptr_o | output | PTR_W | Tagged result pointer |
| rsp_tag_o | output | 4 | Result tag |

## Verification
The hardest case to reach from the ports is the longest stepping path: step count 15 with only one or two tags allowed, so every move wraps nearly the whole tag ring. The bench reaches it in add/subtract mode by loading the configuration mask directly and setting the start tag through the pointer field. The random-mode sequence can only be steered through the seed, so the bench writes chosen seeds into the state register. It then lets a model of the four LFSR steps track the state across long runs of mixed requests. Those runs include full masks and masks that exclude the start tag.

// File: rtl/tag_gen_pkg.sv
package tag_gen_pkg;
  localparam int TAG_W = 4;
  localparam int NTAGS = 1 << TAG_W;

  typedef enum logic {
    OP_RAND   = 1'b0,
    OP_ADDSUB = 1'b1
  } tag_op_e;

  typedef enum logic {
    SEL_MASK  = 1'b0,
    SEL_STATE = 1'b1
  } cfg_sel_e;
endpackage

// File: rtl/tag_lfsr_step.sv
module tag_lfsr_step #(
  parameter int SEED_W = 16,
  parameter int STEPS  = 4
) (
  input  logic [SEED_W-1:0] seed_i,
  output logic [STEPS-1:0]  ofs_o,
  output logic [SEED_W-1:0] seed_o
);
  logic [SEED_W-1:0] chain [STEPS+1];

  assign chain[0] = seed_i;

  for (genvar i = 0; i < STEPS; i++) begin : g_step
    logic fb;
    assign fb          = chain[i][5] ^ chain[i][3] ^ chain[i][2] ^ chain[i][0];
    assign ofs_o[i]    = fb;
    assign chain[i+1]  = {fb, chain[i][SEED_W-1:1]};
  end

  assign seed_o = chain[STEPS];
endmodule

// File: rtl/tag_cfg_regs.sv
module tag_cfg_regs
  import tag_gen_pkg::*;
#(
  parameter int SEED_W   = 16,
  parameter int SEED_LSB = 8,
  parameter int CFG_W    = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic              sel_i,
  input  logic [CFG_W-1:0]  wdata_i,
  output logic [CFG_W-1:0]  rdata_o,
  input  logic              upd_i,
  input  logic [TAG_W-1:0]  upd_tag_i,
  input  logic [SEED_W-1:0] upd_seed_i,
  output logic [NTAGS-1:0]  mask_o,
  output logic [TAG_W-1:0]  tag_o,
  output logic [SEED_W-1:0] seed_o
);
  logic [NTAGS-1:0]  mask_q;
  logic [TAG_W-1:0]  tag_q;
  logic [SEED_W-1:0] seed_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q <= '0;
      tag_q  <= '0;
      seed_q <= '0;
    end else if (we_i) begin
      if (sel_i == SEL_MASK) begin
        mask_q <= wdata_i[NTAGS-1:0];
      end else begin
        tag_q  <= wdata_i[TAG_W-1:0];
        seed_q <= wdata_i[SEED_LSB +: SEED_W];
      end
    end else if (upd_i) begin
      tag_q  <= upd_tag_i;
      seed_q <= upd_seed_i;
    end
  end

  always_comb begin
    rdata_o = '0;
    if (sel_i == SEL_MASK) begin
      rdata_o[NTAGS-1:0] = mask_q;
    end else begin
      rdata_o[TAG_W-1:0]           = tag_q;
      rdata_o[SEED_LSB +: SEED_W]  = seed_q;
    end
  end

  logic unused_wdata;
  assign unused_wdata = ^wdata_i;

  assign mask_o = mask_q;
  assign tag_o  = tag_q;
  assign seed_o = seed_q;
endmodule

// File: rtl/tag_stepper.sv
module tag_stepper
  import tag_gen_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [TAG_W-1:0] tag_i,
  input  logic [TAG_W-1:0] cnt_i,
  input  logic [NTAGS-1:0] mask_i,
  output logic             busy_o,
  output logic             fin_o,
  output logic [TAG_W-1:0] fin_tag_o,
  output logic             done_o,
  output logic [TAG_W-1:0] tag_o,
  output logic [NTAGS-1:0] mask_o
);
  logic             run_q, done_q;
  logic [TAG_W-1:0] t_q, c_q, t_nxt;
  logic [NTAGS-1:0] m_q;
  logic             all_ex;

  assign t_nxt     = t_q + 1'b1;
  assign all_ex    = &m_q;
  // terminal cycle: all excluded, or no moves left and current tag allowed
  assign fin_o     = run_q && (all_ex || (c_q == '0 && !m_q[t_q]));
  assign fin_tag_o = all_ex ? '0 : t_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q  <= 1'b0;
      done_q <= 1'b0;
      t_q    <= '0;
      c_q    <= '0;
      m_q    <= '0;
    end else begin
      done_q <= 1'b0;
      if (!run_q) begin
        if (start_i) begin
          t_q   <= tag_i;
          c_q   <= cnt_i;
          m_q   <= mask_i;
          run_q <= 1'b1;
        end
      end else if (fin_o) begin
        t_q    <= fin_tag_o;
        run_q  <= 1'b0;
        done_q <= 1'b1;
      end else if (c_q == '0) begin
        t_q <= t_nxt;
      end else begin
        t_q <= t_nxt;
        if (!m_q[t_nxt]) c_q <= c_q - 1'b1;
      end
    end
  end

  assign busy_o = run_q;
  assign done_o = done_q;
  assign tag_o  = t_q;
  assign mask_o = m_q;
endmodule

// File: rtl/excl_tag_gen.sv
module excl_tag_gen
  import tag_gen_pkg::*;
#(
  parameter int PTR_W    = 64,
  parameter int TAG_LSB  = 56,
  parameter int OFS_W    = 16,
  parameter int SEED_W   = 16,
  parameter int SEED_LSB = 8,
  parameter int CFG_W    = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_valid_i,
  output logic             req_ready_o,
  input  logic             req_op_i,
  input  logic [PTR_W-1:0] req_ptr_i,
  input  logic [15:0]      req_mask_i,
  input  logic [3:0]       req_tag_ofs_i,
  input  logic [OFS_W-1:0] req_addr_ofs_i,
  input  logic             cfg_we_i,
  input  logic             cfg_sel_i,
  input  logic [CFG_W-1:0] cfg_wdata_i,
  output logic [CFG_W-1:0] cfg_rdata_o,
  output logic             rsp_valid_o,
  output logic [PTR_W-1:0] rsp_ptr_o,
  output logic [3:0]       rsp_tag_o
);
  localparam int EXT_W = PTR_W - OFS_W;

  logic              accept, busy, fin, done;
  logic [TAG_W-1:0]  fin_tag, step_tag, st_tag, lfsr_ofs, start_tag, start_cnt;
  logic [SEED_W-1:0] st_seed, seed_adv;
  logic [NTAGS-1:0]  cfg_mask, start_mask, step_mask;
  logic [PTR_W-1:0]  base_q, base_d;
  logic [SEED_W-1:0] seed_q;
  logic              op_q;

  assign req_ready_o = !busy;
  assign accept      = req_valid_i && req_ready_o;

  tag_cfg_regs #(
    .SEED_W(SEED_W), .SEED_LSB(SEED_LSB), .CFG_W(CFG_W)
  ) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .we_i       (cfg_we_i),
    .sel_i      (cfg_sel_i),
    .wdata_i    (cfg_wdata_i),
    .rdata_o    (cfg_rdata_o),
    .upd_i      (fin && op_q == OP_RAND),
    .upd_tag_i  (fin_tag),
    .upd_seed_i (seed_q),
    .mask_o     (cfg_mask),
    .tag_o      (st_tag),
    .seed_o     (st_seed)
  );

  tag_lfsr_step #(.SEED_W(SEED_W), .STEPS(TAG_W)) u_lfsr (
    .seed_i (st_seed),
    .ofs_o  (lfsr_ofs),
    .seed_o (seed_adv)
  );

  always_comb begin
    if (req_op_i == OP_RAND) begin
      start_tag  = st_tag;
      start_cnt  = lfsr_ofs;
      start_mask = req_mask_i | cfg_mask;
      base_d     = req_ptr_i;
    end else begin
      start_tag  = req_ptr_i[TAG_LSB +: TAG_W];
      start_cnt  = req_tag_ofs_i;
      start_mask = cfg_mask;
      base_d     = req_ptr_i + {{EXT_W{req_addr_ofs_i[OFS_W-1]}}, req_addr_ofs_i};
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      op_q   <= OP_RAND;
      base_q <= '0;
      seed_q <= '0;
    end else if (accept) begin
      op_q   <= req_op_i;
      base_q <= base_d;
      seed_q <= seed_adv;
    end
  end

  tag_stepper u_step (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (accept),
    .tag_i     (start_tag),
    .cnt_i     (start_cnt),
    .mask_i    (start_mask),
    .busy_o    (busy),
    .fin_o     (fin),
    .fin_tag_o (fin_tag),
    .done_o    (done),
    .tag_o     (step_tag),
    .mask_o    (step_mask)
  );

  always_comb begin
    rsp_ptr_o                      = base_q;
    rsp_ptr_o[TAG_LSB +: TAG_W]    = step_tag;
  end

  assign rsp_valid_o = done;
  assign rsp_tag_o   = step_tag;
endmodule

// File: rtl/excl_tag_gen_sva.sv
module excl_tag_gen_sva #(
  parameter int PTR_W   = 64,
  parameter int TAG_LSB = 56
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             req_valid_i,
  input logic             req_ready_o,
  input logic             cfg_we_i,
  input logic             rsp_valid_o,
  input logic [PTR_W-1:0] rsp_ptr_o,
  input logic [3:0]       rsp_tag_o,
  input logic [15:0]      step_mask,
  input logic             op_q,
  input logic [3:0]       st_tag
);
  assert_full_mask_zero_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o && (&step_mask) |-> rsp_tag_o == 4'd0);

  assert_tag_allowed_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o && !(&step_mask) |-> !step_mask[rsp_tag_o]);

  assert_single_pulse_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |=> !rsp_valid_o);

  assert_busy_after_accept_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && req_ready_o |=> !req_ready_o);

  assert_tag_field_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> rsp_ptr_o[TAG_LSB +: 4] == rsp_tag_o);

  assert_state_tag_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o && op_q == 1'b0 && !$past(cfg_we_i) |-> st_tag == rsp_tag_o);
endmodule

bind excl_tag_gen excl_tag_gen_sva #(.PTR_W(PTR_W), .TAG_LSB(TAG_LSB)) u_sva (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_valid_i (req_valid_i),
  .req_ready_o (req_ready_o),
  .cfg_we_i    (cfg_we_i),
  .rsp_valid_o (rsp_valid_o),
  .rsp_ptr_o   (rsp_ptr_o),
  .rsp_tag_o   (rsp_tag_o),
  .step_mask   (step_mask),
  .op_q        (op_q),
  .st_tag      (st_tag)
);

// File: tb/excl_tag_gen_tb.sv
module excl_tag_gen_tb;
  import tag_gen_pkg::*;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, req_ready, req_op;
  logic [63:0] req_ptr;
  logic [15:0] req_mask;
  logic [3:0]  req_tofs;
  logic [15:0] req_aofs;
  logic        cfg_we, cfg_sel;
  logic [31:0] cfg_wdata, cfg_rdata;
  logic        rsp_valid;
  logic [63:0] rsp_ptr;
  logic [3:0]  rsp_tag;

  always #(CLK_PERIOD/2) clk = ~clk;

  excl_tag_gen u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_op_i(req_op),
    .req_ptr_i(req_ptr), .req_mask_i(req_mask), .req_tag_ofs_i(req_tofs),
    .req_addr_ofs_i(req_aofs),
    .cfg_we_i(cfg_we), .cfg_sel_i(cfg_sel), .cfg_wdata_i(cfg_wdata), .cfg_rdata_o(cfg_rdata),
    .rsp_valid_o(rsp_valid), .rsp_ptr_o(rsp_ptr), .rsp_tag_o(rsp_tag)
  );

  typedef struct {
    logic [63:0] ptr;
    logic [3:0]  tag;
    string       rq;
  } exp_t;

  exp_t        exp_q[$];
  int          checks = 0;
  int          fails  = 0;
  logic [15:0] m_mask = '0;
  logic [3:0]  m_tag  = '0;
  logic [15:0] m_seed = '0;

  task automatic check(input bit ok, input string rq, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", rq, act, exp);
    end
  endtask

  function automatic logic [3:0] pick(logic [3:0] t, logic [3:0] n, logic [15:0] x);
    if (x == 16'hffff) return 4'd0;
    if (n == 0) begin
      while (x[t]) t = t + 1'b1;
      return t;
    end
    for (int k = 0; k < int'(n); k++) begin
      t = t + 1'b1;
      while (x[t]) t = t + 1'b1;
    end
    return t;
  endfunction

  task automatic send(input logic op, input logic [63:0] ptr, input logic [15:0] um,
                      input logic [3:0] tofs, input logic [15:0] aofs, input string rq);
    exp_t e;
    logic [15:0] s;
    logic [3:0]  o;
    logic        fb;
    while (!req_ready) @(negedge clk);
    if (op == OP_RAND) begin
      s = m_seed;
      o = '0;
      for (int i = 0; i < 4; i++) begin
        fb   = s[5] ^ s[3] ^ s[2] ^ s[0];
        s    = {fb, s[15:1]};
        o[i] = fb;
      end
      e.tag = pick(m_tag, o, um | m_mask);
      e.ptr = ptr;
      m_tag = e.tag;
      m_seed = s;
    end else begin
      e.tag = pick(ptr[59:56], tofs, m_mask);
      e.ptr = ptr + {{48{aofs[15]}}, aofs};
    end
    e.ptr[59:56] = e.tag;
    e.rq = rq;
    exp_q.push_back(e);
    req_valid = 1'b1; req_op = op; req_ptr = ptr; req_mask = um;
    req_tofs = tofs; req_aofs = aofs;
    @(negedge clk);
    req_valid = 1'b0;
    check(req_ready == 1'b0, "R8 busy after accept", {63'd0, req_ready}, 64'd0);
  endtask

  task automatic drain();
    while (exp_q.size() != 0 || !req_ready) @(negedge clk);
  endtask

  task automatic cfg_write(input logic sel, input logic [31:0] d);
    drain();
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
    if (sel == SEL_MASK) m_mask = d[15:0];
    else begin m_tag = d[3:0]; m_seed = d[23:8]; end
  endtask

  task automatic cfg_check(input logic sel, input string rq);
    logic [31:0] e;
    drain();
    cfg_sel = sel;
    #1;
    e = (sel == SEL_MASK) ? {16'd0, m_mask} : {8'd0, m_seed, 4'd0, m_tag};
    check(cfg_rdata == e, rq, {32'd0, cfg_rdata}, {32'd0, e});
  endtask

  // monitor / scoreboard
  logic prev_valid = 1'b0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (rsp_valid) begin
        if (prev_valid) check(1'b0, "R8 pulse longer than one cycle", 64'd1, 64'd0);
        if (exp_q.size() == 0) begin
          check(1'b0, "R8 unexpected response", 64'd1, 64'd0);
        end else begin
          exp_t e;
          e = exp_q.pop_front();
          check(rsp_tag == e.tag, {e.rq, " tag"}, {60'd0, rsp_tag}, {60'd0, e.tag});
          check(rsp_ptr == e.ptr, {e.rq, " R7 ptr"}, rsp_ptr, e.ptr);
        end
      end
      prev_valid = rsp_valid;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL R8 watchdog: pending %0d expected 0", exp_q.size());
    $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_op = 1'b0; req_ptr = '0; req_mask = '0;
    req_tofs = '0; req_aofs = '0; cfg_we = 1'b0; cfg_sel = 1'b0; cfg_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R9 reset state
    check(req_ready == 1'b1, "R9 reset ready", {63'd0, req_ready}, 64'd1);
    check(rsp_valid == 1'b0, "R9 reset rsp_valid", {63'd0, rsp_valid}, 64'd0);
    cfg_check(SEL_MASK, "R9 reset mask");
    cfg_check(SEL_STATE, "R9 reset state");

    // R9/R5 writes and layout
    cfg_write(SEL_STATE, 32'hFF_ACE1_F3);
    cfg_check(SEL_STATE, "R9 R5 state write readback");
    cfg_write(SEL_MASK, 32'hFFFF_0101);
    cfg_check(SEL_MASK, "R9 mask write readback");
    cfg_write(SEL_MASK, 32'h0);

    // R4 random with plain seed, R5 update
    send(OP_RAND, 64'h0A00_1234_5678_9ABC, 16'h0000, 4'd9, 16'h7777, "R4 random seed ACE1");
    cfg_check(SEL_STATE, "R5 state after random");
    send(OP_RAND, 64'h0000_0000_0000_1000, 16'h00F0, 4'd0, 16'h0, "R4 R6 random operand mask");
    cfg_check(SEL_STATE, "R5 state after second random");

    // R1 all-ones via operand mask
    send(OP_RAND, 64'h0F00_0000_0000_0040, 16'hFFFF, 4'd0, 16'h0, "R1 full operand mask");
    cfg_check(SEL_STATE, "R1 R5 state tag zero");

    // R2 add/subtract, offset zero
    send(OP_ADDSUB, 64'h0500_0000_0000_1000, 16'hFFFF, 4'd0, 16'hFFF0, "R2 R6 start allowed");
    cfg_write(SEL_MASK, 32'h0000_8000);
    send(OP_ADDSUB, 64'h0F00_0000_0000_0000, 16'h0, 4'd0, 16'h0010, "R2 wrap past 15");
    cfg_check(SEL_STATE, "R5 addsub leaves state");

    // R3 long paths
    cfg_write(SEL_MASK, 32'h0000_7FFE);
    send(OP_ADDSUB, 64'h0000_0000_0000_0000, 16'h0, 4'd15, 16'h8000, "R3 two allowed tags");
    cfg_write(SEL_MASK, 32'h0000_FFFE);
    send(OP_ADDSUB, 64'h0300_0000_FFFF_FFF0, 16'h0, 4'd15, 16'h0020, "R3 R10 single allowed");
    cfg_write(SEL_MASK, 32'h0000_0F0F);
    send(OP_ADDSUB, 64'hF7FF_FFFF_FFFF_FFFF, 16'h0, 4'd5, 16'h0001, "R3 R7 carry into tag");

    // R6 mask OR in random mode, R1 via config mask
    cfg_write(SEL_STATE, 32'h00_1357_02);
    cfg_write(SEL_MASK, 32'h0000_0004);
    send(OP_RAND, 64'h1111_2222_3333_4444, 16'h0008, 4'd0, 16'h0, "R6 OR of masks");
    cfg_write(SEL_MASK, 32'h0000_FFFF);
    send(OP_ADDSUB, 64'h0900_0000_0000_0000, 16'h0, 4'd7, 16'h0004, "R1 full config mask");
    send(OP_RAND, 64'h0900_0000_0000_0000, 16'h0, 4'd0, 16'h0, "R1 full config mask random");
    cfg_check(SEL_STATE, "R5 state after full mask");

    // mixed runs
    cfg_write(SEL_STATE, 32'h00_BEEF_07);
    for (int i = 0; i < 80; i++) begin
      logic [15:0] um;
      if (i % 10 == 0) cfg_write(SEL_MASK, (i % 30 == 0) ? 32'h0 : {16'd0, 16'($urandom)});
      um = (i % 13 == 5) ? 16'hFFFF : 16'($urandom) & 16'($urandom);
      send(1'($urandom), {$urandom, $urandom}, um, 4'($urandom), 16'($urandom), "R3 R4 R10 mixed");
    end
    cfg_check(SEL_STATE, "R5 state after mixed");

    drain();
    repeat (3) @(negedge clk);
    $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule